// File: doc/BRIEF.md
# Indirect Register Transfer Bridge

This block sits between a byte-wide host window and a network controller that exposes only two 16-bit ports: a register-address pointer port and a register data port. The host never touches the controller directly. It places a word in a pair of write byte latches, sets the direction and the target port in a control register, and then stores any value at a command location. That store launches one full 16-bit transfer on the controller side. A read transfer lands in a separate pair of read byte latches, so reading the data bytes returns the last word fetched from the controller, never the word most recently written.

The control register and the status register share one byte address: a host write sets control, a host read returns status. The status byte shows whether a transfer is still running and whether the controller is raising its interrupt. The control register also drives the controller's active-low reset. On the controller side, the bridge holds a select line, a write or read strobe and the outgoing word steady until the controller answers with ready. It finishes the transfer on that same clock edge.

Top module: `reg_xfer_bridge`

## Requirements
- R1: After reset the status byte reads 0x10 when no interrupt is pending, both read data bytes read 0, no strobe is active, and the controller reset output is low.
- R2: The host window has four byte offsets. Offset 0 is the low data byte and offset 1 the high data byte. Offset 2 is control on write and status on read. Offset 3 is the command byte.
- R3: Control bit 3 drives the controller reset output from the clock edge that stores it: 0 holds the controller in reset and 1 releases it.
- R4: Control bit 0 selects the target port. The select output is 1 for the address-pointer port and 0 for the data port.
- R5: Control bit 1 selects the direction: 0 is a write to the controller and 1 is a read from it.
- R6: A host write of any value to offset 3 while idle starts a transfer. From the next cycle status bit 5 reads 1 and exactly one strobe is active. In a write transfer the outgoing word is {high write byte, low write byte}.
- R7: A transfer ends on the first clock edge at which ready is high. Busy and the strobe drop on that edge, and on a read the controller word is captured into the read bytes on the same edge.
- R8: Status bit 4 reads the inverse of the controller interrupt input, so 0 means an interrupt is pending.
- R9: Host reads of offsets 0 and 1 return the read byte latches, not the values written there.
- R10: A command write issued while busy is ignored, and does not start a second transfer after the current one ends.
- R11: Select, direction and outgoing word are frozen at launch. A control or data-byte write during a transfer does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_addr | input | 2 | Host byte offset |
| hb_wr | input | 1 | Host write strobe, one cycle per byte |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte for hb_addr |
| dev_rst_n | output | 1 | Controller reset, active low |
| dev_sel | output | 1 | Target port: 1 pointer, 0 data |
| dev_we | output | 1 | Write strobe, held until ready |
| dev_re | output | 1 | Read strobe, held until ready |
| dev_wdata | output | 16 | Word written to the controller |
| dev_rdata | input | 16 | Word returned by the controller |
| dev_ready | input | 1 | Controller completes the transfer |
| dev_irq | input | 1 | Controller interrupt, active high |

## Verification
The transfer path is swept over every combination of direction and target, with ready latencies of zero to three cycles. Each combination carries a word that differs in both bytes. This separates a swapped byte lane, a swapped port select, a wrong strobe and an early or late busy clear. Read transfers return a word unlike the one in the write latches, which exposes a read-back taken from the wrong latch. Long transfers receive a command write and a new control and data setting partway through, which tells a frozen launch apart from one that follows the host. The interrupt input and the reset bit are toggled in both directions, and the command byte is tried with several values, including zero.

// File: rtl/reg_xfer_pkg.sv
package reg_xfer_pkg;
  localparam int BYTE_W    = 8;
  localparam int CT_TGT    = 0;
  localparam int CT_DIR    = 1;
  localparam int CT_RST    = 3;
  localparam int ST_IRQN   = 4;
  localparam int ST_BUSY   = 5;

  function automatic logic [BYTE_W-1:0] status_byte(input logic busy, input logic irq);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_BUSY] = busy;
    s[ST_IRQN] = ~irq;
    return s;
  endfunction
endpackage

// File: rtl/reg_xfer_host.sv
module reg_xfer_host
  import reg_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic              hb_wr,
  input  logic [BYTE_W-1:0] hb_wdata,
  output logic [BYTE_W-1:0] hb_rdata,
  input  logic              busy,
  input  logic              irq,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] cap_word,
  output logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word,
  output logic              ctl_rst,
  output logic              ctl_dir,
  output logic              ctl_tgt,
  output logic              cmd_hit,
  output logic              ctrl_hit
);
  localparam int NB = DATA_W / BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(NB + 1);

  assign cmd_hit  = hb_wr && (hb_addr == CMD_OFS);
  assign ctrl_hit = hb_wr && (hb_addr == CTRL_OFS);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic lane_wr;
    assign lane_wr = hb_wr && (hb_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_word[i*BYTE_W +: BYTE_W] <= '0;
        rd_word[i*BYTE_W +: BYTE_W] <= '0;
      end else begin
        if (lane_wr) wr_word[i*BYTE_W +: BYTE_W] <= hb_wdata;
        if (cap_evt) rd_word[i*BYTE_W +: BYTE_W] <= cap_word[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rst <= 1'b0;
      ctl_dir <= 1'b0;
      ctl_tgt <= 1'b0;
    end else if (ctrl_hit) begin
      ctl_rst <= hb_wdata[CT_RST];
      ctl_dir <= hb_wdata[CT_DIR];
      ctl_tgt <= hb_wdata[CT_TGT];
    end
  end

  always_comb begin
    hb_rdata = '0;
    if (hb_addr == CTRL_OFS) hb_rdata = status_byte(busy, irq);
    for (int i = 0; i < NB; i++)
      if (hb_addr == ADDR_W'(i)) hb_rdata = rd_word[i*BYTE_W +: BYTE_W];
  end

  AST_CTRL_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> ctl_rst == $past(hb_wdata[CT_RST])); // R3
endmodule

// File: rtl/reg_xfer_engine.sv
module reg_xfer_engine #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic              cfg_dir,
  input  logic              cfg_tgt,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              dev_ready,
  output logic              busy,
  output logic              launch_evt,
  output logic              done_evt,
  output logic              cap_evt,
  output logic              dev_sel,
  output logic              dev_we,
  output logic              dev_re,
  output logic [DATA_W-1:0] dev_wdata
);
  logic dir_q;

  assign launch_evt = launch_req && !busy;
  assign done_evt   = busy && dev_ready;
  assign cap_evt    = done_evt && dir_q;
  assign dev_we     = busy && !dir_q;
  assign dev_re     = busy && dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_q     <= 1'b0;
      dev_sel   <= 1'b0;
      dev_wdata <= '0;
    end else if (launch_evt) begin
      busy      <= 1'b1;
      dir_q     <= cfg_dir;
      dev_sel   <= cfg_tgt;
      dev_wdata <= cfg_word;
    end else if (done_evt) begin
      busy      <= 1'b0;
    end
  end

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch_req && !busy |=> busy); // R6
  AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dev_ready |=> !busy && !dev_we && !dev_re); // R7
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dev_ready |=> $stable(dev_sel) && $stable(dev_wdata) && $stable(dev_we)); // R11
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && launch_req && !dev_ready |=> busy); // R10
endmodule

// File: rtl/reg_xfer_bridge.sv
module reg_xfer_bridge
  import reg_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DATA_W / BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic              hb_wr,
  input  logic [BYTE_W-1:0] hb_wdata,
  output logic [BYTE_W-1:0] hb_rdata,
  output logic              dev_rst_n,
  output logic              dev_sel,
  output logic              dev_we,
  output logic              dev_re,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_ready,
  input  logic              dev_irq
);
  logic              busy, launch_evt, done_evt, cap_evt;
  logic              ctl_rst, ctl_dir, ctl_tgt, cmd_hit, ctrl_hit;
  logic [DATA_W-1:0] wr_word, rd_word;

  reg_xfer_host #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .busy(busy), .irq(dev_irq),
    .cap_evt(cap_evt), .cap_word(dev_rdata), .wr_word(wr_word),
    .rd_word(rd_word), .ctl_rst(ctl_rst), .ctl_dir(ctl_dir),
    .ctl_tgt(ctl_tgt), .cmd_hit(cmd_hit), .ctrl_hit(ctrl_hit)
  );

  reg_xfer_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch_req(cmd_hit), .cfg_dir(ctl_dir),
    .cfg_tgt(ctl_tgt), .cfg_word(wr_word), .dev_ready(dev_ready),
    .busy(busy), .launch_evt(launch_evt), .done_evt(done_evt),
    .cap_evt(cap_evt), .dev_sel(dev_sel), .dev_we(dev_we), .dev_re(dev_re),
    .dev_wdata(dev_wdata)
  );

  assign dev_rst_n = ctl_rst;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_we && dev_re)); // R6
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_re && dev_ready |=> rd_word == $past(dev_rdata)); // R7
  AST_LAUNCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt && !ctl_dir |=> dev_we && dev_wdata == $past(wr_word)); // R6
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (dev_we || dev_re)); // R7
endmodule

// File: tb/test_reg_xfer_bridge.sv
module test_reg_xfer_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hb_addr = '0;
  logic        hb_wr = 1'b0;
  logic [7:0]  hb_wdata = '0;
  logic [7:0]  hb_rdata;
  logic        dev_rst_n, dev_sel, dev_we, dev_re;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;
  logic        dev_ready = 1'b0;
  logic        dev_irq = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_xfer_bridge i_reg_xfer_bridge (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .dev_rst_n(dev_rst_n),
    .dev_sel(dev_sel), .dev_we(dev_we), .dev_re(dev_re),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready),
    .dev_irq(dev_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    hb_addr = a;
    #0.5;
    d = hb_rdata;
  endtask

  function automatic logic [7:0] exp_status(input bit busy, input bit irq);
    return (busy ? 8'h20 : 8'h00) | (irq ? 8'h00 : 8'h10);
  endfunction

  // one transfer; when disturb is set, a command, control and data write arrive mid-transfer
  task automatic run_xfer(input bit dir, input bit tgt, input logic [15:0] w,
                          input logic [15:0] rw, input int lat, input logic [7:0] cmd,
                          input bit disturb);
    logic [7:0] b;
    hwrite(2'd0, w[7:0]);
    hwrite(2'd1, w[15:8]);
    hwrite(2'd2, {4'b1000, 2'b00, dir, tgt});
    hwrite(2'd3, cmd);
    hread(2'd2, b);
    chk("R6 busy after command", b, exp_status(1, 0));
    chk("R4 select", dev_sel, tgt);
    chk("R5 write strobe", dev_we, !dir);
    chk("R5 read strobe", dev_re, dir);
    if (!dir) chk("R6 outgoing word", dev_wdata, w);
    if (disturb) begin
      hwrite(2'd2, {4'b1000, 2'b00, !dir, !tgt});
      hwrite(2'd0, ~w[7:0]);
      hwrite(2'd3, 8'h00);
      chk("R11 select frozen", dev_sel, tgt);
      chk("R11 strobe frozen", dev_re, dir);
      if (!dir) chk("R11 word frozen", dev_wdata, w);
      hread(2'd2, b);
      chk("R10 still busy", b, exp_status(1, 0));
    end
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      hread(2'd2, b);
      chk("R7 busy until ready", b, exp_status(1, 0));
    end
    @(negedge clk);
    dev_ready = 1'b1; dev_rdata = rw;
    @(negedge clk);
    dev_ready = 1'b0; dev_rdata = 16'h0;
    hread(2'd2, b);
    chk("R7 idle after ready", b, exp_status(0, 0));
    chk("R7 strobes low", {dev_we, dev_re}, 2'b00);
    if (dir) begin
      hread(2'd0, b); chk("R9 low read byte", b, rw[7:0]);
      hread(2'd1, b); chk("R9 high read byte", b, rw[15:8]);
    end
    if (disturb) begin
      repeat (3) @(negedge clk);
      hread(2'd2, b);
      chk("R10 no second transfer", {b, dev_we, dev_re}, {exp_status(0, 0), 2'b00});
    end
  endtask

  initial begin
    logic [7:0] b;
    logic [15:0] w, rw, last_rw;
    int idx;
    repeat (3) @(negedge clk);
    hread(2'd2, b); chk("R1 status", b, 8'h10);
    hread(2'd0, b); chk("R1 low read byte", b, 8'h00);
    hread(2'd1, b); chk("R1 high read byte", b, 8'h00);
    chk("R1 strobes", {dev_we, dev_re}, 2'b00);
    chk("R1 reset out", dev_rst_n, 1'b0);
    rst_n = 1'b1;
    hwrite(2'd2, 8'h08); chk("R3 release", dev_rst_n, 1'b1);
    hwrite(2'd2, 8'h00); chk("R3 hold", dev_rst_n, 1'b0);
    hwrite(2'd2, 8'h08); chk("R3 release again", dev_rst_n, 1'b1);
    dev_irq = 1'b1; #0.5; hread(2'd2, b); chk("R8 irq pending", b, 8'h00);
    dev_irq = 1'b0; #0.5; hread(2'd2, b); chk("R8 irq clear", b, 8'h10);
    idx = 0;
    last_rw = 16'h0;
    for (int dir = 0; dir < 2; dir++)
      for (int tgt = 0; tgt < 2; tgt++)
        for (int lat = 0; lat < 4; lat++) begin
          w  = 16'hA5C3 ^ (16'(idx) * 16'h1111);
          rw = {w[7:0], w[15:8]} ^ 16'h0F3C;
          run_xfer(dir[0], tgt[0], w, rw, lat, 8'(idx * 37), 1'b0);
          if (dir == 0) begin
            hread(2'd0, b);
            chk("R9 write not read back", b, last_rw[7:0]);
          end else last_rw = rw;
          idx++;
        end
    run_xfer(1'b0, 1'b1, 16'h1234, 16'h0, 2, 8'hFF, 1'b1);
    run_xfer(1'b1, 1'b0, 16'hBEEF, 16'h7E81, 3, 8'h5A, 1'b1);
    hwrite(2'd0, 8'h99);
    hread(2'd0, b); chk("R2 R9 offset0 reads latch", b, 8'h81);
    hread(2'd1, b); chk("R2 R9 offset1 reads latch", b, 8'h7E);
    hread(2'd3, b); chk("R2 command reads zero", b, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule